// File: doc/BRIEF.md
# Configurable SPI Master Serial Engine

This block is the serial engine of an SPI master. It takes transmit words from a valid/ready source, shifts them out on MOSI while it samples MISO, and hands each received word to a valid/ready sink. It drives SCLK and one chip select. A set of plain configuration pins selects the clock divider, the word length (8, 12, 16 or 32 bits), the bit order, the idle SCLK level, the inactive chip-select level and the SCLK edge on which MOSI changes. A frame is a single word, or a run of words whose count is programmed. The configuration is captured when a frame starts.

A frame starts when the engine is idle and both enable inputs are high. After the frame the engine waits until the two enables are no longer both high before it can start again, so software-style level enables do not start a second frame by accident. The engine reports each completed word, the end of the frame, transmit underflow and receive overflow as one-cycle pulses.

Back-pressure rules: `tx_ready` is a one-cycle pulse in the cycle before a word's first bit must be driven. The source must already hold `tx_valid` high with the word in that cycle; the engine never waits for it. `rx_valid` stays high, with `rx_data` unchanged, until the sink accepts the word with `rx_ready`. The engine cannot stall the serial clock, so a late source causes an underflow and a slow sink causes an overflow.

Top module: `spi_wordlink`

## Requirements
- R1: SCLK holds each level for `cfg_div`+1 core cycles. The first SCLK edge comes `cfg_div`+1 cycles after the start edge, and chip select goes to its active level on that start edge.
- R2: `cfg_fmt` selects the word length: 0 gives 8 bits, 1 gives 12, 2 gives 16 and 3 gives 32. A frame of W words produces exactly 2·N·W SCLK edges, where N is the word length.
- R3: When `cfg_msb_first` is 1, bit N-1 of a word is sent and received first. When it is 0, bit 0 is sent and received first.
- R4: While no frame runs, SCLK sits at `cfg_cpol` and chip select sits at `cfg_cs_idle`. During a frame, chip select is driven to the inverse of `cfg_cs_idle`.
- R5: When `cfg_drive_rise` is 1, MOSI changes only on rising SCLK edges and MISO is sampled on falling edges. When it is 0, the two edges swap. If the first edge of the frame is a sampling edge, the first bit is already on MOSI from the start edge.
- R6: With `cfg_multi` at 0 a frame carries one word. With `cfg_multi` at 1 it carries `cfg_len`+1 words, back to back. `word_done` pulses once per word, on the core edge that samples the word's last bit.
- R7: Chip select returns to its inactive level `cfg_div`+1 cycles after the last SCLK edge. `frame_end` pulses in that same cycle.
- R8: A frame starts only when the engine is idle and both `rx_en` and `tx_en` are 1. After a frame, no new frame starts until the two enables are no longer both high.
- R9: When `cfg_cs_manual` is 1, chip select follows `cfg_cs_level` directly, whatever the engine state.
- R10: `tx_ready` is a one-cycle pulse for each word. If `tx_valid` is 0 during that pulse, `tx_uflow` pulses the next cycle and the word is sent as all zeros. Bits of `tx_data` at positions N and above are ignored.
- R11: A received word is held on `rx_data` with `rx_valid` high until `rx_ready` is 1. If a new word completes while a held word is still waiting and `rx_ready` is 0, `rx_oflow` pulses and the new word is dropped.
- R12: For 8-, 12- and 16-bit words, the bits of `rx_data` at positions N and above are zero.
- R13: After reset, no frame runs, `rx_valid` is 0 and every event output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | DIV_W | SCLK half period minus one, in core cycles |
| cfg_fmt | input | 2 | Word length select |
| cfg_msb_first | input | 1 | 1 = MSB first, 0 = LSB first |
| cfg_cpol | input | 1 | Idle SCLK level |
| cfg_cs_idle | input | 1 | Inactive chip-select level |
| cfg_drive_rise | input | 1 | 1 = MOSI changes on rising SCLK edges |
| cfg_multi | input | 1 | Multi-word frame enable |
| cfg_len | input | LEN_W | Word count minus one for a multi-word frame |
| cfg_cs_manual | input | 1 | Chip select is driven directly from `cfg_cs_level` |
| cfg_cs_level | input | 1 | Chip-select level used in manual mode |
| rx_en | input | 1 | Receive enable |
| tx_en | input | 1 | Transmit enable |
| tx_data | input | 32 | Transmit word |
| tx_valid | input | 1 | Transmit word is present |
| tx_ready | output | 1 | One-cycle request for the next transmit word |
| rx_data | output | 32 | Received word |
| rx_valid | output | 1 | Received word is held |
| rx_ready | input | 1 | Sink accepts the held word |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_cs | output | 1 | Chip select |
| spi_miso | input | 1 | Serial data in |
| word_done | output | 1 | Pulse: a word has completed |
| frame_end | output | 1 | Pulse: the frame has ended and chip select is released |
| tx_uflow | output | 1 | Pulse: no transmit word was present when one was due |
| rx_oflow | output | 1 | Pulse: a received word was dropped |

## Verification
The assertions take `rx_ready` to be a level that the sink holds for a full cycle. They read chip select and SCLK against the live `cfg_cpol` and `cfg_cs_idle`, so the idle-level checks assume these two pins change only while no frame runs. The stimulus changes every configuration pin only in a cycle before the enables are raised, and holds it until the frame has ended. It drives MISO one cycle ahead of each sampling edge. In each frame it either keeps `rx_ready` high for the whole frame or low for the whole frame.

// File: rtl/spi_wordlink_pkg.sv
package spi_wordlink_pkg;
  localparam int WORD_MAX = 32;

  typedef enum logic [1:0] {
    FMT_8  = 2'd0,
    FMT_12 = 2'd1,
    FMT_16 = 2'd2,
    FMT_32 = 2'd3
  } word_fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } seq_state_e;

  function automatic logic [5:0] fmt_bits(input logic [1:0] f);
    case (f)
      2'd0:    return 6'd8;
      2'd1:    return 6'd12;
      2'd2:    return 6'd16;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [WORD_MAX-1:0] fmt_mask(input logic [5:0] n);
    if (n == 6'd32) return '1;
    return (WORD_MAX'(1) << n) - WORD_MAX'(1);
  endfunction
endpackage

// File: rtl/spi_wl_halftimer.sv
module spi_wl_halftimer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/spi_wl_txshift.sv
module spi_wl_txshift
  import spi_wordlink_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                shift,
  input  logic                clear,
  input  logic                msb_first,
  input  logic [5:0]          nbits,
  input  logic [WORD_MAX-1:0] word_in,
  output logic                bit_out
);
  logic [WORD_MAX-1:0] sh;
  logic [WORD_MAX-1:0] masked;

  assign masked  = word_in & fmt_mask(nbits);
  assign bit_out = msb_first ? sh[WORD_MAX-1] : sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (clear) sh <= '0;
    else if (load)  sh <= msb_first ? (masked << (6'd32 - nbits)) : masked;
    else if (shift) sh <= msb_first ? (sh << 1) : (sh >> 1);
  end
endmodule

// File: rtl/spi_wl_rxshift.sv
module spi_wl_rxshift
  import spi_wordlink_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample,
  input  logic                bit_in,
  input  logic                msb_first,
  input  logic [5:0]          nbits,
  output logic [WORD_MAX-1:0] word_now
);
  logic [WORD_MAX-1:0] rsh;
  logic [WORD_MAX-1:0] rsh_nx;

  assign rsh_nx   = msb_first ? {rsh[WORD_MAX-2:0], bit_in} : {bit_in, rsh[WORD_MAX-1:1]};
  assign word_now = msb_first ? (rsh_nx & fmt_mask(nbits)) : (rsh_nx >> (6'd32 - nbits));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsh <= '0;
    else if (sample) rsh <= rsh_nx;
  end
endmodule

// File: rtl/spi_wordlink.sv
module spi_wordlink
  import spi_wordlink_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int LEN_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic [1:0]          cfg_fmt,
  input  logic                cfg_msb_first,
  input  logic                cfg_cpol,
  input  logic                cfg_cs_idle,
  input  logic                cfg_drive_rise,
  input  logic                cfg_multi,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                cfg_cs_manual,
  input  logic                cfg_cs_level,
  input  logic                rx_en,
  input  logic                tx_en,
  input  logic [WORD_MAX-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic [WORD_MAX-1:0] rx_data,
  output logic                rx_valid,
  input  logic                rx_ready,
  output logic                spi_sclk,
  output logic                spi_mosi,
  output logic                spi_cs,
  input  logic                spi_miso,
  output logic                word_done,
  output logic                frame_end,
  output logic                tx_uflow,
  output logic                rx_oflow
);
  localparam int EW = LEN_W + 7;

  seq_state_e          state;
  logic [DIV_W-1:0]    div_q;
  logic [5:0]          n_q;
  logic                msb_q;
  logic [EW-1:0]       edges_left;
  logic                samp_next;
  logic [4:0]          sbit, dbit;
  logic                sclk_q;
  logic [WORD_MAX-1:0] rx_hold;
  logic                rx_hold_v;

  logic                run, tick, start_go, cpha_live;
  logic [5:0]          n_live;
  logic [EW-1:0]       edges_total;
  logic                edge_now, fin_now, samp_now, drv_now, drv_load, drv_shift, word_end;
  logic                tx_bit;
  logic [WORD_MAX-1:0] rx_word;

  assign run         = (state == ST_RUN);
  assign start_go    = (state == ST_IDLE) && rx_en && tx_en;
  assign cpha_live   = cfg_cpol ^ cfg_drive_rise;
  assign n_live      = fmt_bits(cfg_fmt);
  assign edges_total = (cfg_multi ? (EW'(cfg_len) + EW'(1)) : EW'(1)) * EW'({n_live, 1'b0});

  assign edge_now  = tick && (edges_left != '0);
  assign fin_now   = tick && (edges_left == '0);
  assign samp_now  = edge_now && samp_next;
  assign drv_now   = edge_now && !samp_next;
  assign drv_load  = drv_now && ({1'b0, dbit} == n_q - 6'd1) && (edges_left > EW'(1));
  assign drv_shift = drv_now && ({1'b0, dbit} != n_q - 6'd1);
  assign word_end  = samp_now && ({1'b0, sbit} == n_q - 6'd1);
  assign tx_ready  = (start_go && !cpha_live) || drv_load;

  spi_wl_halftimer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_q), .tick(tick)
  );

  spi_wl_txshift u_tx (
    .clk(clk), .rst_n(rst_n),
    .load(tx_ready), .shift(drv_shift), .clear(start_go && cpha_live),
    .msb_first(start_go ? cfg_msb_first : msb_q),
    .nbits(start_go ? n_live : n_q),
    .word_in(tx_valid ? tx_data : '0),
    .bit_out(tx_bit)
  );

  spi_wl_rxshift u_rx (
    .clk(clk), .rst_n(rst_n), .sample(samp_now), .bit_in(spi_miso),
    .msb_first(msb_q), .nbits(n_q), .word_now(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      div_q      <= '0;
      n_q        <= 6'd8;
      msb_q      <= 1'b0;
      edges_left <= '0;
      samp_next  <= 1'b0;
      sbit       <= '0;
      dbit       <= '0;
      sclk_q     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start_go) begin
          state      <= ST_RUN;
          div_q      <= cfg_div;
          n_q        <= n_live;
          msb_q      <= cfg_msb_first;
          edges_left <= edges_total;
          samp_next  <= !cpha_live;
          sbit       <= '0;
          dbit       <= cpha_live ? 5'(n_live - 6'd1) : 5'd0;
          sclk_q     <= cfg_cpol;
        end
        ST_RUN: begin
          if (edge_now) begin
            sclk_q     <= !sclk_q;
            edges_left <= edges_left - EW'(1);
            samp_next  <= !samp_next;
          end
          if (samp_now) sbit <= word_end ? 5'd0 : sbit + 5'd1;
          if (drv_load)       dbit <= 5'd0;
          else if (drv_shift) dbit <= dbit + 5'd1;
          if (fin_now) state <= ST_HOLD;
        end
        default: if (!(rx_en && tx_en)) state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_hold   <= '0;
      rx_hold_v <= 1'b0;
      word_done <= 1'b0;
      frame_end <= 1'b0;
      tx_uflow  <= 1'b0;
      rx_oflow  <= 1'b0;
    end else begin
      word_done <= word_end;
      frame_end <= fin_now;
      tx_uflow  <= tx_ready && !tx_valid;
      rx_oflow  <= word_end && rx_hold_v && !rx_ready;
      if (word_end && !(rx_hold_v && !rx_ready)) begin
        rx_hold   <= rx_word;
        rx_hold_v <= 1'b1;
      end else if (rx_hold_v && rx_ready) begin
        rx_hold_v <= 1'b0;
      end
    end
  end

  assign rx_data  = rx_hold;
  assign rx_valid = rx_hold_v;
  assign spi_sclk = run ? sclk_q : cfg_cpol;
  assign spi_mosi = run && tx_bit;
  assign spi_cs   = cfg_cs_manual ? cfg_cs_level : (run ? !cfg_cs_idle : cfg_cs_idle);
endmodule

// File: rtl/spi_wordlink_chk.sv
module spi_wordlink_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_cpol,
  input logic        cfg_cs_idle,
  input logic        cfg_cs_manual,
  input logic        spi_sclk,
  input logic        spi_cs,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic [31:0] rx_data,
  input logic        word_done,
  input logic        frame_end,
  input logic        tx_uflow,
  input logic        rx_oflow
);
  // R11: a word waiting without acceptance stays put
  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  // R11: a dropped word only happens when a word completes
  a_r11_oflow_on_word: assert property (@(posedge clk) disable iff (!rst_n)
    rx_oflow |-> word_done);

  // R7: chip select is inactive when the frame-end pulse appears
  a_r7_cs_released: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && !cfg_cs_manual |-> spi_cs == cfg_cs_idle);

  // R4: SCLK rests at its idle level whenever chip select is inactive
  a_r4_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_cs_manual && spi_cs == cfg_cs_idle |-> spi_sclk == cfg_cpol);

  // R10: the request is a single-cycle pulse
  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);

  // R10: underflow follows a request that found no word
  a_r10_uflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tx_uflow |-> $past(tx_ready && !tx_valid));
endmodule

bind spi_wordlink spi_wordlink_chk u_chk (.*);

// File: tb/spi_wordlink_test.sv
module spi_wordlink_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_div = '0;
  logic [1:0]  cfg_fmt = '0;
  logic        cfg_msb_first = 1'b1, cfg_cpol = 1'b0, cfg_cs_idle = 1'b1, cfg_drive_rise = 1'b0;
  logic        cfg_multi = 1'b0, cfg_cs_manual = 1'b0, cfg_cs_level = 1'b0;
  logic [15:0] cfg_len = '0;
  logic        rx_en = 1'b0, tx_en = 1'b0;
  logic [31:0] tx_data = '0;
  logic        tx_valid = 1'b0, rx_ready = 1'b0, spi_miso = 1'b0;
  logic        tx_ready, rx_valid, spi_sclk, spi_mosi, spi_cs;
  logic        word_done, frame_end, tx_uflow, rx_oflow;
  logic [31:0] rx_data;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  logic [31:0] txw [8];
  logic [31:0] slw [8];

  always #10 clk = ~clk;

  spi_wordlink uut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_fmt(cfg_fmt),
    .cfg_msb_first(cfg_msb_first), .cfg_cpol(cfg_cpol), .cfg_cs_idle(cfg_cs_idle),
    .cfg_drive_rise(cfg_drive_rise), .cfg_multi(cfg_multi), .cfg_len(cfg_len),
    .cfg_cs_manual(cfg_cs_manual), .cfg_cs_level(cfg_cs_level),
    .rx_en(rx_en), .tx_en(tx_en), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs(spi_cs), .spi_miso(spi_miso),
    .word_done(word_done), .frame_end(frame_end), .tx_uflow(tx_uflow), .rx_oflow(rx_oflow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] maskn(input int n);
    return (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  function automatic logic pick(input logic [31:0] w, input int n, input int p, input logic msb);
    return msb ? w[n-1-p] : w[p];
  endfunction

  task automatic run_frame(input logic [1:0] fmt, input logic msb, input logic cpol,
                           input logic drv, input int words, input int div,
                           input logic csi, input logic [7:0] vmask, input logic rdy);
    int n, cpha, d, e, nb, cur, rxi, edges, bad5, h, s, j, jj, w, lw;
    bit pend, running, exp_fe, exp_wd, exp_uf, exp_of, ld;
    logic ps, pm, exp_mosi;
    n = (fmt == 2'd0) ? 8 : (fmt == 2'd1) ? 12 : (fmt == 2'd2) ? 16 : 32;
    cpha = int'(cpol ^ drv);
    d = div + 1; e = 2 * n * words; nb = n * words;
    cur = 0; rxi = 0; edges = 0; bad5 = 0;
    @(negedge clk);
    cfg_fmt = fmt; cfg_msb_first = msb; cfg_cpol = cpol; cfg_drive_rise = drv;
    cfg_div = 16'(div); cfg_cs_idle = csi; cfg_multi = (words > 1);
    cfg_len = 16'(words - 1); rx_ready = rdy; spi_miso = 1'b0;
    tx_data = txw[0]; tx_valid = vmask[0];
    @(negedge clk);
    rx_en = 1'b1; tx_en = 1'b1;
    #1 pend = tx_ready; ps = spi_sclk; pm = spi_mosi;
    for (int t = 0; t <= (e + 1) * d + 3; t++) begin
      @(negedge clk);
      if (pend) begin
        cur++;
        tx_data  = (cur < words) ? txw[cur] : 32'h0;
        tx_valid = (cur < words) ? vmask[cur] : 1'b0;
        pend = 0;
      end
      h = t / d;
      running = (h <= e);
      s = (t > 0 && t % d == 0) ? t / d : 0;
      exp_mosi = 1'b0;
      if (running) begin
        j = -1;
        if (cpha == 0) j = h / 2;
        else if (h > 0) j = (h - 1) / 2;
        if (j >= nb) j = nb - 1;
        if (j >= 0) begin
          w = j / n;
          exp_mosi = vmask[w] ? pick(txw[w], n, j % n, msb) : 1'b0;
        end
      end
      exp_fe = (t == (e + 1) * d);
      exp_wd = (s > 0) && (s <= e) && ((s - cpha + 1) % (2 * n) == 0);
      exp_of = exp_wd && !rdy && ((s - cpha + 1) / (2 * n) - 1 >= 1);
      ld = 0; lw = 0;
      if (cpha == 0 && t == 0) ld = 1;
      if (cpha == 0 && s > 0 && s < e && s % (2 * n) == 0) begin ld = 1; lw = s / (2 * n); end
      if (cpha == 1 && s > 0 && s < e && s % (2 * n) == 1) begin ld = 1; lw = (s - 1) / (2 * n); end
      exp_uf = ld && !vmask[lw];
      chk("R1 sclk level", {31'b0, spi_sclk}, {31'b0, running ? (cpol ^ h[0]) : cpol});
      chk("R4 chip select", {31'b0, spi_cs}, {31'b0, running ? !csi : csi});
      chk("R3 mosi bit", {31'b0, spi_mosi}, {31'b0, exp_mosi});
      chk("R7 frame_end", {31'b0, frame_end}, {31'b0, exp_fe});
      chk("R6 word_done", {31'b0, word_done}, {31'b0, exp_wd});
      chk("R10 tx_uflow", {31'b0, tx_uflow}, {31'b0, exp_uf});
      chk("R11 rx_oflow", {31'b0, rx_oflow}, {31'b0, exp_of});
      if (spi_sclk !== ps) begin
        edges++;
        if (spi_sclk === !drv && spi_mosi !== pm) bad5++;
      end
      if (rx_valid && rx_ready) begin
        chk("R12 rx word", rx_data, slw[rxi] & maskn(n));
        rxi++;
      end
      ps = spi_sclk; pm = spi_mosi;
      pend = tx_ready;
      spi_miso = 1'b0;
      jj = t / d - cpha;
      if (jj >= 0) begin
        j = jj / 2;
        if (j < nb) spi_miso = pick(slw[j / n], n, j % n, msb);
      end
    end
    chk("R2 edge count", 32'(edges), 32'(e));
    chk("R5 mosi stable on sampling edge", 32'(bad5), 32'd0);
    chk("R8 no restart while enables stay high", {31'b0, spi_cs}, {31'b0, csi});
    if (rdy) chk("R11 words delivered", 32'(rxi), 32'(words));
    else begin
      @(negedge clk);
      rx_ready = 1'b1;
      #1 chk("R11 held word valid", {31'b0, rx_valid}, 32'd1);
      chk("R11 held word kept", rx_data, slw[0] & maskn(n));
      @(negedge clk);
      chk("R11 held word consumed", {31'b0, rx_valid}, 32'd0);
    end
    @(negedge clk);
    rx_en = 1'b0; tx_en = 1'b0; tx_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 reset cs", {31'b0, spi_cs}, 32'd1);
    chk("R13 reset sclk", {31'b0, spi_sclk}, 32'd0);
    chk("R13 reset mosi", {31'b0, spi_mosi}, 32'd0);
    chk("R13 reset rx_valid", {31'b0, rx_valid}, 32'd0);
    chk("R13 reset events", {28'b0, word_done, frame_end, tx_uflow, rx_oflow}, 32'd0);

    // R8: one enable alone does not start a frame
    tx_en = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R8 single enable idle cs", {31'b0, spi_cs}, 32'd1);
      chk("R8 single enable no request", {31'b0, tx_ready}, 32'd0);
    end
    tx_en = 1'b0;

    // R9: manual chip select
    @(negedge clk);
    cfg_cs_manual = 1'b1; cfg_cs_level = 1'b0;
    #1 chk("R9 manual low", {31'b0, spi_cs}, 32'd0);
    cfg_cs_level = 1'b1;
    #1 chk("R9 manual high", {31'b0, spi_cs}, 32'd1);
    @(negedge clk);
    cfg_cs_manual = 1'b0;

    txw[0] = 32'hFFFF_FFA5; slw[0] = 32'h1234_563C;
    run_frame(2'd0, 1'b1, 1'b0, 1'b0, 1, 1, 1'b1, 8'hFF, 1'b1);

    txw[0] = 32'h0000_0A5C; txw[1] = 32'hABCD_E3E1; txw[2] = 32'h0000_0777;
    slw[0] = 32'hFFFF_F9C3; slw[1] = 32'h0000_0421; slw[2] = 32'h5555_5ABE;
    run_frame(2'd1, 1'b0, 1'b1, 1'b0, 3, 2, 1'b0, 8'hFF, 1'b1);

    txw[0] = 32'h7777_C0DE; txw[1] = 32'h0000_8001;
    slw[0] = 32'hAAAA_BEEF; slw[1] = 32'h0000_4002;
    run_frame(2'd2, 1'b1, 1'b0, 1'b1, 2, 0, 1'b1, 8'hFF, 1'b1);

    txw[0] = 32'hDEAD_BEEF; slw[0] = 32'h8123_4567;
    run_frame(2'd3, 1'b0, 1'b1, 1'b1, 1, 1, 1'b1, 8'hFF, 1'b1);

    txw[0] = 32'h0000_00C3; txw[1] = 32'h0000_00FF;
    slw[0] = 32'h0000_0081; slw[1] = 32'h0000_0042;
    run_frame(2'd0, 1'b1, 1'b0, 1'b0, 2, 1, 1'b1, 8'h01, 1'b1);

    txw[0] = 32'h0000_0011; txw[1] = 32'h0000_0022;
    slw[0] = 32'h0000_00E7; slw[1] = 32'h0000_0018;
    run_frame(2'd0, 1'b1, 1'b1, 1'b1, 2, 1, 1'b1, 8'hFF, 1'b0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule